// File: doc/BRIEF.md
# MIDI UART Port

This block is a MIDI serial port that a host drives through a small byte-wide register window. Serial MIDI frames that arrive on the receive line are turned into bytes and held in a 128-entry receive queue. The host drains the queue a byte at a time and reads a status byte. The host writes bytes that the block sends out on the transmit line.

The host window has two offsets. Offset 0 is the data port: a read returns and removes the oldest received byte, and a write hands a byte to the transmitter. Offset 1 returns the status byte on a read and takes a command byte on a write. The only command acted on is the port reset, 0xFF. It empties the queue, stops any transmission, clears the overrun flag and leaves the acknowledge byte 0xFE as the only entry to be read.

The bit rate is 31250 bits per second in both directions, derived from the parameter clock frequency. The receiver samples each bit near its middle using a 16x oversampling tick. Decoding of the legacy base address (one of four 16-byte-aligned positions from 0x300 to 0x330) is done outside the block, which sees only the one-bit offset.

Top module: `midi_uart_port`

## Requirements
- R1: Serial frames in both directions are one low start bit, eight data bits with the least significant bit first, and one high stop bit. Each bit lasts CLK_HZ/31250 clocks (16 oversampling ticks). The transmit line idles high.
- R2: A frame on rxd_i whose start bit is still low at its middle is sampled at the centre of each data bit. When its stop bit reads high, the byte is appended to the receive queue.
- R3: With host_sel_i = 0, host_rdata_o shows the oldest queued byte, and a host_rd_i strobe removes it at the next clock edge. When the queue is empty the data port reads 0x00 and a read strobe changes nothing. Bytes come out in arrival order.
- R4: The queue holds 128 bytes. A byte that completes while 128 are held is discarded and sets a sticky overrun flag. Only a port reset command or rst_i clears the flag.
- R5: With host_sel_i = 1, host_rdata_o is the status byte: bit 7 = queue empty, bit 6 = transmit holding byte occupied (a data write would be lost), bit 5 = overrun, bits 4..0 = 0. Reading the status byte alters nothing.
- R6: A data-port write while the holding byte is free is accepted. Its start bit begins one clock after the accepting edge if the transmitter is idle, or right after the current stop bit otherwise.
- R7: A data-port write while the holding byte is occupied is discarded, and no frame is ever sent for it.
- R8: A command write of 0xFF to offset 1 empties the queue, aborts transmission with txd_o high, frees the holding byte and clears overrun. The queue is then left holding the single byte 0xFE. A command byte of any other value has no effect.
- R9: A frame whose stop bit reads low is discarded. The receiver then waits for rxd_i to return high before it accepts a new start bit.
- R10: While rst_i is high on a clock edge, the block returns to an empty queue, a cleared overrun flag, an idle transmitter and txd_o high. The status byte reads 0x80 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock, frequency CLK_HZ |
| rst_i | input | 1 | Synchronous active-high reset |
| host_sel_i | input | 1 | Host offset: 0 data port, 1 status/command port |
| host_rd_i | input | 1 | Host read strobe, one cycle per access |
| host_wr_i | input | 1 | Host write strobe, one cycle per access |
| host_wdata_i | input | 8 | Host write byte |
| host_rdata_o | output | 8 | Host read byte for the selected offset (combinational) |
| rxd_i | input | 1 | Serial MIDI input, asynchronous |
| txd_o | output | 1 | Serial MIDI output |

## Verification
Host reads are combinational, so the bench samples host_rdata_o about a nanosecond after changing host_sel_i at a falling edge. A read strobe takes effect at the following rising edge, and the bench samples its result at the falling edge after that. A transmitted start bit appears one clock after the write is accepted. The bench detects that falling edge at a falling clock edge and then samples each bit half a bit period (16 clocks) into it. A received byte reaches the queue within two synchroniser clocks after the middle of its stop bit, so the bench waits until half a bit period after the stop bit ends before it looks at status or data.

// File: rtl/midi_uart_pkg.sv
package midi_uart_pkg;

    localparam int unsigned BYTE_W     = 8;
    localparam int unsigned FRAME_BITS = 10;   // start + 8 data + stop

    localparam logic [BYTE_W-1:0] CMD_PORT_RESET = 8'hFF;
    localparam logic [BYTE_W-1:0] ACK_BYTE       = 8'hFE;
    localparam logic [BYTE_W-1:0] EMPTY_READ     = 8'h00;

    typedef enum logic {
        PORT_DATA = 1'b0,
        PORT_CTRL = 1'b1
    } port_sel_e;

    typedef struct packed {
        logic       rx_empty;   // bit 7
        logic       tx_full;    // bit 6
        logic       overrun;    // bit 5
        logic [4:0] zero;       // bits 4..0
    } status_t;

    typedef struct packed {
        logic              valid;
        logic [BYTE_W-1:0] data;
    } byte_strobe_t;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP,
        RX_HOLD
    } rx_state_e;

    function automatic int unsigned div_round(input int unsigned num, input int unsigned den);
        return (num + den / 2) / den;
    endfunction

endpackage

// File: rtl/midi_tick_gen.sv
module midi_tick_gen #(
    parameter int unsigned DIV = 100
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic clr_i,
    output logic tick_o
);
    localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk_i) begin
        if (rst_i || clr_i) begin
            cnt    <= '0;
            tick_o <= 1'b0;
        end else if (cnt == LAST) begin
            cnt    <= '0;
            tick_o <= 1'b1;
        end else begin
            cnt    <= cnt + 1'b1;
            tick_o <= 1'b0;
        end
    end

endmodule

// File: rtl/midi_rx.sv
module midi_rx
    import midi_uart_pkg::*;
#(
    parameter int unsigned OVERSAMPLE = 16
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic         clr_i,
    input  logic         tick_i,
    input  logic         rxd_i,
    output byte_strobe_t rx_o
);
    localparam int unsigned TW = $clog2(OVERSAMPLE);
    localparam logic [TW-1:0] MID_TICK  = TW'(OVERSAMPLE / 2 - 1);
    localparam logic [TW-1:0] LAST_TICK = TW'(OVERSAMPLE - 1);

    logic [1:0]        sync_q;
    logic              rxs;
    rx_state_e         state;
    logic [TW-1:0]     tcnt;
    logic [2:0]        bitn;
    logic [BYTE_W-1:0] shreg;

    assign rxs = sync_q[1];

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            sync_q <= 2'b11;
        end else begin
            sync_q <= {sync_q[0], rxd_i};
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i || clr_i) begin
            state <= RX_IDLE;
            tcnt  <= '0;
            bitn  <= '0;
            shreg <= '0;
            rx_o  <= '0;
        end else begin
            rx_o.valid <= 1'b0;
            unique case (state)
                RX_IDLE: begin
                    if (!rxs) begin
                        state <= RX_START;
                        tcnt  <= '0;
                    end
                end
                RX_START: begin
                    if (tick_i) begin
                        if (tcnt == MID_TICK) begin
                            tcnt <= '0;
                            if (rxs) begin
                                state <= RX_IDLE;
                            end else begin
                                state <= RX_DATA;
                                bitn  <= '0;
                            end
                        end else begin
                            tcnt <= tcnt + 1'b1;
                        end
                    end
                end
                RX_DATA: begin
                    if (tick_i) begin
                        if (tcnt == LAST_TICK) begin
                            tcnt  <= '0;
                            shreg <= {rxs, shreg[BYTE_W-1:1]};
                            if (bitn == 3'd7) begin
                                state <= RX_STOP;
                            end else begin
                                bitn <= bitn + 1'b1;
                            end
                        end else begin
                            tcnt <= tcnt + 1'b1;
                        end
                    end
                end
                RX_STOP: begin
                    if (tick_i) begin
                        if (tcnt == LAST_TICK) begin
                            tcnt <= '0;
                            if (rxs) begin
                                rx_o.valid <= 1'b1;
                                rx_o.data  <= shreg;
                                state      <= RX_IDLE;
                            end else begin
                                state <= RX_HOLD;
                            end
                        end else begin
                            tcnt <= tcnt + 1'b1;
                        end
                    end
                end
                RX_HOLD: begin
                    if (rxs) begin
                        state <= RX_IDLE;
                    end
                end
                default: state <= RX_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/midi_rx_fifo.sv
module midi_rx_fifo
    import midi_uart_pkg::*;
#(
    parameter int unsigned DEPTH = 128,
    localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned LW   = $clog2(DEPTH) + 1
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              flush_i,
    input  logic              push_i,
    input  logic [BYTE_W-1:0] wdata_i,
    input  logic              pop_i,
    output logic [BYTE_W-1:0] head_o,
    output logic [LW-1:0]     level_o,
    output logic              full_o,
    output logic              empty_o
);
    logic [BYTE_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wptr;
    logic [AW-1:0]     rptr;
    logic              do_push;
    logic              do_pop;

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full_o  = (level_o == LW'(DEPTH));
    assign empty_o = (level_o == '0);
    assign do_push = push_i && !full_o;
    assign do_pop  = pop_i && !empty_o;
    assign head_o  = mem[rptr];

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            wptr    <= '0;
            rptr    <= '0;
            level_o <= '0;
        end else if (flush_i) begin
            rptr    <= '0;
            wptr    <= push_i ? step('0) : '0;
            level_o <= push_i ? LW'(1) : '0;
        end else begin
            if (do_push) begin
                wptr <= step(wptr);
            end
            if (do_pop) begin
                rptr <= step(rptr);
            end
            unique case ({do_push, do_pop})
                2'b10:   level_o <= level_o + 1'b1;
                2'b01:   level_o <= level_o - 1'b1;
                default: level_o <= level_o;
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (flush_i && push_i) begin
            mem[0] <= wdata_i;
        end else if (!flush_i && do_push) begin
            mem[wptr] <= wdata_i;
        end
    end

endmodule

// File: rtl/midi_tx.sv
module midi_tx
    import midi_uart_pkg::*;
#(
    parameter int unsigned BIT_CLKS = 1600
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              clr_i,
    input  logic              load_i,
    input  logic [BYTE_W-1:0] data_i,
    output logic              txd_o,
    output logic              full_o
);
    localparam int unsigned CW = (BIT_CLKS > 1) ? $clog2(BIT_CLKS) : 1;
    localparam logic [CW-1:0] LAST_CLK = CW'(BIT_CLKS - 1);
    localparam logic [3:0]    LAST_BIT = 4'(FRAME_BITS - 1);

    logic              busy;
    logic [CW-1:0]     bcnt;
    logic [3:0]        sent;
    logic [BYTE_W:0]   shreg;
    logic [BYTE_W-1:0] hold_d;

    always_ff @(posedge clk_i) begin
        if (rst_i || clr_i) begin
            full_o <= 1'b0;
            busy   <= 1'b0;
            txd_o  <= 1'b1;
            bcnt   <= '0;
            sent   <= '0;
            shreg  <= '1;
            hold_d <= '0;
        end else begin
            if (load_i && !full_o) begin
                full_o <= 1'b1;
                hold_d <= data_i;
            end
            if (busy) begin
                if (bcnt == LAST_CLK) begin
                    bcnt <= '0;
                    if (sent == LAST_BIT) begin
                        busy <= 1'b0;
                    end else begin
                        txd_o <= shreg[0];
                        shreg <= {1'b1, shreg[BYTE_W:1]};
                        sent  <= sent + 1'b1;
                    end
                end else begin
                    bcnt <= bcnt + 1'b1;
                end
            end else if (full_o) begin
                busy   <= 1'b1;
                full_o <= 1'b0;
                txd_o  <= 1'b0;
                shreg  <= {1'b1, hold_d};
                bcnt   <= '0;
                sent   <= '0;
            end
        end
    end

endmodule

// File: rtl/midi_uart_port.sv
module midi_uart_port
    import midi_uart_pkg::*;
#(
    parameter int unsigned CLK_HZ     = 50_000_000,
    parameter int unsigned BIT_RATE   = 31_250,
    parameter int unsigned OVERSAMPLE = 16,
    parameter int unsigned FIFO_DEPTH = 128
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              host_sel_i,
    input  logic              host_rd_i,
    input  logic              host_wr_i,
    input  logic [BYTE_W-1:0] host_wdata_i,
    output logic [BYTE_W-1:0] host_rdata_o,
    input  logic              rxd_i,
    output logic              txd_o
);
    localparam int unsigned TICK_DIV = div_round(CLK_HZ, BIT_RATE * OVERSAMPLE);
    localparam int unsigned BIT_CLKS = TICK_DIV * OVERSAMPLE;
    localparam int unsigned LVL_W    = $clog2(FIFO_DEPTH) + 1;

    port_sel_e         sel;
    logic              cmd_reset;
    logic              data_wr;
    logic              data_rd;
    logic              tick;
    byte_strobe_t      rx_byte;
    logic              fifo_push;
    logic [BYTE_W-1:0] fifo_wdata;
    logic [BYTE_W-1:0] fifo_head;
    logic [LVL_W-1:0]  fifo_level;
    logic              fifo_full;
    logic              fifo_empty;
    logic              tx_full;
    logic              overrun_q;
    status_t           status;

    assign sel       = port_sel_e'(host_sel_i);
    assign cmd_reset = host_wr_i && (sel == PORT_CTRL) && (host_wdata_i == CMD_PORT_RESET);
    assign data_wr   = host_wr_i && (sel == PORT_DATA);
    assign data_rd   = host_rd_i && (sel == PORT_DATA);

    midi_tick_gen #(
        .DIV    (TICK_DIV)
    ) u_tick (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .clr_i  (cmd_reset),
        .tick_o (tick)
    );

    midi_rx #(
        .OVERSAMPLE (OVERSAMPLE)
    ) u_rx (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .clr_i  (cmd_reset),
        .tick_i (tick),
        .rxd_i  (rxd_i),
        .rx_o   (rx_byte)
    );

    assign fifo_push  = cmd_reset || rx_byte.valid;
    assign fifo_wdata = cmd_reset ? ACK_BYTE : rx_byte.data;

    midi_rx_fifo #(
        .DEPTH   (FIFO_DEPTH)
    ) u_fifo (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .flush_i (cmd_reset),
        .push_i  (fifo_push),
        .wdata_i (fifo_wdata),
        .pop_i   (data_rd),
        .head_o  (fifo_head),
        .level_o (fifo_level),
        .full_o  (fifo_full),
        .empty_o (fifo_empty)
    );

    midi_tx #(
        .BIT_CLKS (BIT_CLKS)
    ) u_tx (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .clr_i  (cmd_reset),
        .load_i (data_wr),
        .data_i (host_wdata_i),
        .txd_o  (txd_o),
        .full_o (tx_full)
    );

    always_ff @(posedge clk_i) begin
        if (rst_i || cmd_reset) begin
            overrun_q <= 1'b0;
        end else if (rx_byte.valid && fifo_full) begin
            overrun_q <= 1'b1;
        end
    end

    always_comb begin
        status.rx_empty = fifo_empty;
        status.tx_full  = tx_full;
        status.overrun  = overrun_q;
        status.zero     = '0;
    end

    always_comb begin
        if (sel == PORT_CTRL) begin
            host_rdata_o = status;
        end else if (fifo_empty) begin
            host_rdata_o = EMPTY_READ;
        end else begin
            host_rdata_o = fifo_head;
        end
    end

endmodule

// File: rtl/midi_uart_port_chk.sv
module midi_uart_port_chk
    import midi_uart_pkg::*;
#(
    parameter int unsigned DEPTH = 128,
    parameter int unsigned LVL_W = 8
) (
    input logic              clk_i,
    input logic              rst_i,
    input logic              host_sel_i,
    input logic              host_wr_i,
    input logic [BYTE_W-1:0] host_wdata_i,
    input logic [BYTE_W-1:0] host_rdata_o,
    input logic              txd_i,
    input logic [LVL_W-1:0]  level_i,
    input logic              overrun_i
);
    logic cmd_seen;
    assign cmd_seen = host_wr_i && host_sel_i && (host_wdata_i == CMD_PORT_RESET);

    AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (rst_i)
        level_i <= LVL_W'(DEPTH)); // R4

    AST_OVERRUN_STICKY: assert property (@(posedge clk_i) disable iff (rst_i)
        ($past(overrun_i) && !$past(cmd_seen)) |-> overrun_i); // R4

    AST_EMPTY_FLAG: assert property (@(posedge clk_i) disable iff (rst_i)
        (host_sel_i && (level_i == '0)) |-> host_rdata_o[7]); // R5

    AST_STATUS_PAD: assert property (@(posedge clk_i) disable iff (rst_i)
        host_sel_i |-> (host_rdata_o[4:0] == 5'd0)); // R5

    AST_CMD_FLUSH: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(cmd_seen) |-> ((level_i == LVL_W'(1)) && txd_i)); // R8

    AST_LEVEL_STEP: assert property (@(posedge clk_i) disable iff (rst_i)
        !$past(cmd_seen) |->
            (((LVL_W+1)'(level_i) <= (LVL_W+1)'($past(level_i)) + (LVL_W+1)'(1)) &&
             ((LVL_W+1)'($past(level_i)) <= (LVL_W+1)'(level_i) + (LVL_W+1)'(1)))); // R3

    AST_TXD_AFTER_RST: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(rst_i) |-> txd_i); // R10

endmodule

bind midi_uart_port midi_uart_port_chk #(
    .DEPTH (FIFO_DEPTH),
    .LVL_W (LVL_W)
) u_chk (
    .clk_i        (clk_i),
    .rst_i        (rst_i),
    .host_sel_i   (host_sel_i),
    .host_wr_i    (host_wr_i),
    .host_wdata_i (host_wdata_i),
    .host_rdata_o (host_rdata_o),
    .txd_i        (txd_o),
    .level_i      (fifo_level),
    .overrun_i    (overrun_q)
);

// File: tb/midi_uart_port_bench.sv
module midi_uart_port_bench;

    localparam int unsigned BENCH_CLK_HZ = 1_000_000;
    localparam int BIT      = 32;        // 1 MHz / 31250 bit/s
    localparam int WATCHDOG = 150_000;
    localparam int NVEC     = 8;
    localparam logic [7:0] VEC [NVEC] = '{8'h00, 8'hFF, 8'h55, 8'hAA,
                                           8'h90, 8'h3C, 8'h01, 8'h80};

    logic       clk   = 1'b0;
    logic       rst   = 1'b1;
    logic       sel   = 1'b0;
    logic       rd    = 1'b0;
    logic       wr    = 1'b0;
    logic       rxd   = 1'b1;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       txd;

    int checks   = 0;
    int errors   = 0;
    bit finished = 1'b0;

    always #10ns clk = ~clk;

    midi_uart_port #(
        .CLK_HZ (BENCH_CLK_HZ)
    ) u_midi_uart_port (
        .clk_i        (clk),
        .rst_i        (rst),
        .host_sel_i   (sel),
        .host_rd_i    (rd),
        .host_wr_i    (wr),
        .host_wdata_i (wdata),
        .host_rdata_o (rdata),
        .rxd_i        (rxd),
        .txd_o        (txd)
    );

    task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic host_write(input logic s, input logic [7:0] d);
        sel   = s;
        wdata = d;
        wr    = 1'b1;
        @(negedge clk);
        wr    = 1'b0;
    endtask

    task automatic get_status(output logic [7:0] s);
        sel = 1'b1;
        #1ns;
        s = rdata;
    endtask

    task automatic pop_data(output logic [7:0] d);
        sel = 1'b0;
        #1ns;
        d  = rdata;
        rd = 1'b1;
        @(negedge clk);
        rd = 1'b0;
    endtask

    task automatic send_frame(input logic [7:0] b, input logic stop_level);
        rxd = 1'b0;
        wait_clk(BIT);
        for (int i = 0; i < 8; i++) begin
            rxd = b[i];
            wait_clk(BIT);
        end
        rxd = stop_level;
        wait_clk(BIT);
        rxd = 1'b1;
        wait_clk(BIT / 2);
    endtask

    task automatic capture_frame(output logic [7:0] b, output logic framing_ok);
        int guard;
        guard = 0;
        b = 8'h00;
        while (txd === 1'b1 && guard < 12 * BIT) begin
            @(negedge clk);
            guard++;
        end
        wait_clk(BIT / 2);
        framing_ok = (txd === 1'b0);
        for (int i = 0; i < 8; i++) begin
            wait_clk(BIT);
            b[i] = txd;
        end
        wait_clk(BIT);
        framing_ok = framing_ok && (txd === 1'b1);
    endtask

    task automatic count_low(input int n, output int lows);
        lows = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (txd !== 1'b1) lows++;
        end
    endtask

    initial begin
        logic [7:0] v;
        logic [7:0] s;
        logic [7:0] va;
        logic [7:0] vb;
        logic       ok;
        logic       oka;
        logic       okb;
        int         lows;

        wait_clk(4);
        rst = 1'b0;
        wait_clk(1);

        // R10: reset state
        get_status(s);
        check8("R10 status after reset", s, 8'h80);
        check8("R10 txd idle after reset", {7'd0, txd}, 8'h01);
        sel = 1'b0;
        #1ns;
        check8("R3 data port while empty", rdata, 8'h00);

        // Vector table: each byte received then echoed out
        for (int i = 0; i < NVEC; i++) begin
            send_frame(VEC[i], 1'b1);
            get_status(s);
            check8("R2 status with one byte queued", s, 8'h00);
            pop_data(v);
            check8("R2 received byte", v, VEC[i]);
            get_status(s);
            check8("R3 empty after pop", s, 8'h80);
            host_write(1'b0, VEC[i]);
            capture_frame(v, ok);
            check8("R6 transmitted byte", v, VEC[i]);
            check8("R1 start low and stop high", {7'd0, ok}, 8'h01);
        end

        // R3: read of an empty queue does not underflow
        pop_data(v);
        check8("R3 empty read value", v, 8'h00);
        send_frame(8'h5A, 1'b1);
        pop_data(v);
        check8("R3 byte after empty read", v, 8'h5A);
        get_status(s);
        check8("R3 single entry after empty read", s, 8'h80);

        // R3: arrival order
        send_frame(8'h12, 1'b1);
        send_frame(8'h34, 1'b1);
        pop_data(v);
        check8("R3 first in order", v, 8'h12);
        pop_data(v);
        check8("R3 second in order", v, 8'h34);

        // R9: low stop bit discards the frame, receiver recovers
        send_frame(8'h55, 1'b0);
        wait_clk(BIT);
        get_status(s);
        check8("R9 framing error frame dropped", s, 8'h80);
        send_frame(8'h66, 1'b1);
        pop_data(v);
        check8("R9 next frame after framing error", v, 8'h66);

        // R8: other command values have no effect
        send_frame(8'h21, 1'b1);
        host_write(1'b1, 8'h3F);
        get_status(s);
        check8("R8 other command leaves status", s, 8'h00);
        count_low(2 * BIT, lows);
        check8("R8 other command sends nothing", 8'(lows), 8'h00);
        pop_data(v);
        check8("R8 other command keeps queue", v, 8'h21);

        // R6 / R7: holding byte full, third write dropped
        fork
            begin
                capture_frame(va, oka);
                capture_frame(vb, okb);
            end
            begin
                host_write(1'b0, 8'hC3);
                wait_clk(3);
                host_write(1'b0, 8'h5E);
                get_status(s);
                check8("R5 tx holding occupied flag", s, 8'hC0);
                host_write(1'b0, 8'h81);
            end
        join
        check8("R6 first queued frame", va, 8'hC3);
        check8("R6 second queued frame", vb, 8'h5E);
        check8("R1 framing of back-to-back frames", {6'd0, oka, okb}, 8'h03);
        count_low(12 * BIT, lows);
        check8("R7 write while occupied never sent", 8'(lows), 8'h00);

        // R4: fill 128, overflow, drain
        for (int i = 0; i < 128; i++) begin
            send_frame(8'(i), 1'b1);
        end
        get_status(s);
        check8("R4 full queue no overrun", s, 8'h00);
        send_frame(8'hA5, 1'b1);
        get_status(s);
        check8("R4 overrun set by 129th byte", s, 8'h20);
        for (int i = 0; i < 128; i++) begin
            pop_data(v);
            check8("R4 drained byte", v, 8'(i));
        end
        get_status(s);
        check8("R4 overrun sticky after drain", s, 8'hA0);

        // R8: port reset command
        send_frame(8'h77, 1'b1);
        host_write(1'b0, 8'h99);
        wait_clk(2 * BIT);
        get_status(s);
        check8("R4 overrun still set before command", s, 8'h20);
        host_write(1'b1, 8'hFF);
        get_status(s);
        check8("R8 status after reset command", s, 8'h00);
        check8("R8 txd high after reset command", {7'd0, txd}, 8'h01);
        pop_data(v);
        check8("R8 acknowledge byte", v, 8'hFE);
        get_status(s);
        check8("R8 only the acknowledge queued", s, 8'h80);
        count_low(12 * BIT, lows);
        check8("R8 aborted frame not resumed", 8'(lows), 8'h00);

        // R10: reset with data queued
        send_frame(8'h42, 1'b1);
        rst = 1'b1;
        wait_clk(2);
        rst = 1'b0;
        wait_clk(1);
        get_status(s);
        check8("R10 status after mid-run reset", s, 8'h80);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule